// File: doc/BRIEF.md
# Prioritized Address Window Chip-Select Decoder

This block sits in front of an external memory bus. For every access it compares the access address with four programmable address windows. It selects exactly one owner for the access. When several windows overlap, a fixed hierarchy decides between them. When no window claims the address, a default region owns it. The winner drives one line of a five-line one-hot chip-select bus. The block also reports the index of the configuration set that governs the access: 0 for the default region, 1 to 4 for the windows. The timing of the bus cycle is handled elsewhere.

Each window has three settings: an enable bit, a base address, and a size field. The size field gives the window length as a power of two in bytes. The decision is registered. A small controller with two states, `ST_IDLE` and `ST_ACTIVE`, loads the chip selects when an access starts. It holds them for the whole access and clears them when the access ends. The windows may change while an access is in flight without disturbing that access.

The controller has two states and four transitions:
- `ST_IDLE` → `ST_ACTIVE` ("start"): taken when `acc_valid` is sampled high. The decision is loaded on this edge.
- `ST_IDLE` → `ST_IDLE` ("wait"): taken while `acc_valid` is low.
- `ST_ACTIVE` → `ST_ACTIVE` ("hold"): taken while `acc_valid` stays high. The outputs are frozen.
- `ST_ACTIVE` → `ST_IDLE` ("end"): taken when `acc_valid` is sampled low. The outputs are cleared.

Top module: `addr_window_cs`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `cs` is all zero and `cfg_sel` is 0 until an access starts.
- R2: Window k (k = 1..4) matches when its enable bit is set and the address bits at positions `size` and above equal the same bits of its base. `size` is the base-2 log of the window length in bytes, from 0 (one byte) up to ADDR_W (the whole space).
- R3: Base bits below position `size` are ignored, so a misaligned base behaves as if it were rounded down to the size.
- R4: A window whose enable bit is clear never matches, whatever its base and size.
- R5: Among matching windows the highest index wins: 4 over 3, 2 over 1, and windows 3 and 4 over windows 1 and 2.
- R6: An address that no window matches selects the default region: `cs` = 5'b00001 and `cfg_sel` = 0.
- R7: `cs` is zero or one-hot. Bit k of `cs` belongs to window k and bit 0 to the default region. When `cs` is non-zero, `cfg_sel` equals the index of the asserted bit.
- R8: In `ST_IDLE`, the first rising edge that samples `acc_valid` high loads the decision for `acc_addr` sampled at that edge. The decision is visible on `cs`/`cfg_sel` right after that edge.
- R9: While `acc_valid` stays high after the start, `cs` and `cfg_sel` stay unchanged, even when the address or the window settings change.
- R10: A rising edge that samples `acc_valid` low clears `cs` to zero and `cfg_sel` to 0. A new access needs at least one such low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | High for the whole duration of an external access |
| acc_addr | input | ADDR_W | Access address |
| win_en | input | NWIN | Enable bit per window; bit k-1 is window k |
| win_base | input | NWIN*ADDR_W | Base addresses; slice k-1 is window k |
| win_size | input | NWIN*SZ_W | Base-2 log of each window length in bytes; slice k-1 is window k |
| cs | output | NWIN+1 | One-hot chip selects; bit 0 is the default region, bit k is window k |
| cfg_sel | output | $clog2(NWIN+1) | Index of the governing configuration set |

## Verification
The decision for an access becomes visible exactly one clock after `acc_valid` is first sampled high. Clearing also happens exactly one clock after `acc_valid` is sampled low. The bench drives inputs just after each falling edge. A behavioural model updates at each rising edge from the inputs it sees there. The outputs are compared with that model at the next falling edge, which is after the single register stage has settled. The directed checks follow the same rule. They read the literal expected window at the first falling edge after the start. They read the all-zero state at the first falling edge after the drop. They also read the frozen value two cycles into a held access after the windows have been changed.

// File: rtl/acw_pkg.sv
package acw_pkg;

    // Controller states of the chip-select decoder
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } acw_state_e;

endpackage

// File: rtl/acw_window_match.sv
module acw_window_match #(
    parameter int ADDR_W = 24,
    parameter int SZ_W   = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [SZ_W-1:0]   size,
    output logic              hit
);

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] diff;

    // Compare only the bits at and above the window size; lower bits are offset
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            keep_mask[i] = (i >= int'(size));
        end
    end

    assign diff = (addr ^ base) & keep_mask;
    assign hit  = en && (diff == '0);

endmodule

// File: rtl/acw_priority.sv
module acw_priority #(
    parameter int NWIN  = 4,
    parameter int IDX_W = 3
) (
    input  logic [NWIN-1:0]  hit,
    output logic [IDX_W-1:0] sel,
    output logic             any_hit
);

    // Later (higher) windows override earlier ones; 0 stays the default region
    always_comb begin
        sel = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (hit[i]) begin
                sel = IDX_W'(i + 1);
            end
        end
    end

    assign any_hit = |hit;

endmodule

// File: rtl/addr_window_cs.sv
module addr_window_cs
    import acw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NWIN   = 4,
    parameter int SZ_W   = 5,
    localparam int IDX_W = $clog2(NWIN + 1),
    localparam int CS_W  = NWIN + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [NWIN-1:0]        win_en,
    input  logic [NWIN*ADDR_W-1:0] win_base,
    input  logic [NWIN*SZ_W-1:0]   win_size,
    output logic [CS_W-1:0]        cs,
    output logic [IDX_W-1:0]       cfg_sel
);

    logic [NWIN-1:0]  hit;
    logic [IDX_W-1:0] sel;
    logic             any_hit;
    logic [CS_W-1:0]  cs_new;

    acw_state_e       state_q;
    acw_state_e       state_d;
    logic [CS_W-1:0]  cs_q;
    logic [IDX_W-1:0] sel_q;

    // One comparator per window
    generate
        for (genvar g = 0; g < NWIN; g++) begin : g_win
            acw_window_match #(
                .ADDR_W (ADDR_W),
                .SZ_W   (SZ_W)
            ) u_match (
                .addr (acc_addr),
                .en   (win_en[g]),
                .base (win_base[g*ADDR_W +: ADDR_W]),
                .size (win_size[g*SZ_W +: SZ_W]),
                .hit  (hit[g])
            );
        end
    endgenerate

    acw_priority #(
        .NWIN  (NWIN),
        .IDX_W (IDX_W)
    ) u_prio (
        .hit     (hit),
        .sel     (sel),
        .any_hit (any_hit)
    );

    always_comb begin
        cs_new      = '0;
        cs_new[sel] = 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_valid)  state_d = ST_ACTIVE;
            ST_ACTIVE: if (!acc_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: load on start, hold during access, clear on end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '0;
            sel_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        cs_q  <= cs_new;
                        sel_q <= sel;
                    end
                end
                ST_ACTIVE: begin
                    if (!acc_valid) begin
                        cs_q  <= '0;
                        sel_q <= '0;
                    end
                end
                default: begin
                    cs_q  <= '0;
                    sel_q <= '0;
                end
            endcase
        end
    end

    assign cs      = cs_q;
    assign cfg_sel = sel_q;

    // R7
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs));

    // R7
    cs_sel_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs != '0) |-> cs[cfg_sel]);

    // R5
    top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[NWIN-1] |-> (sel == IDX_W'(NWIN)));

    // R6
    default_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (sel == '0));

    // R8
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && acc_valid) |=> (cfg_sel == $past(sel)));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && acc_valid) |=> ($stable(cs) && $stable(cfg_sel)));

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (cs == '0 && cfg_sel == '0));

endmodule

// File: tb/addr_window_cs_test.sv
module addr_window_cs_test;

    localparam int AW = 24;
    localparam int NW = 4;
    localparam int SW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic [AW-1:0]   acc_addr = '0;
    logic [NW-1:0]   win_en;
    logic [NW*AW-1:0] win_base;
    logic [NW*SW-1:0] win_size;
    logic [NW:0]     cs;
    logic [2:0]      cfg_sel;

    logic [AW-1:0]   base_r [NW];
    logic [SW-1:0]   size_r [NW];
    logic            en_r   [NW];

    int n_checks = 0;
    int n_fail   = 0;
    bit model_on = 1'b0;
    string cur_req = "R8";

    always #2 clk = ~clk;

    always_comb begin
        for (int w = 0; w < NW; w++) begin
            win_en[w]            = en_r[w];
            win_base[w*AW +: AW] = base_r[w];
            win_size[w*SW +: SW] = size_r[w];
        end
    end

    addr_window_cs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .win_en    (win_en),
        .win_base  (win_base),
        .win_size  (win_size),
        .cs        (cs),
        .cfg_sel   (cfg_sel)
    );

    // Behavioural reference: highest enabled window whose upper bits agree
    function automatic int ref_owner(logic [AW-1:0] a);
        int owner = 0;
        for (int w = 0; w < NW; w++) begin
            if (en_r[w] && ((a >> size_r[w]) == (base_r[w] >> size_r[w])))
                owner = w + 1;
        end
        return owner;
    endfunction

    bit         m_busy = 1'b0;
    logic [NW:0] exp_cs = '0;
    int         exp_sel = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; exp_cs = '0; exp_sel = 0;
        end else if (!m_busy && acc_valid) begin
            m_busy = 1'b1;
            exp_sel = ref_owner(acc_addr);
            exp_cs = '0;
            exp_cs[exp_sel] = 1'b1;
        end else if (m_busy && !acc_valid) begin
            m_busy = 1'b0; exp_cs = '0; exp_sel = 0;
        end
    end

    task automatic check(string req, int want_sel, logic [NW:0] want_cs);
        n_checks++;
        if (cs !== want_cs || int'(cfg_sel) != want_sel) begin
            n_fail++;
            $display("FAIL %s: cs=%b cfg_sel=%0d expected cs=%b cfg_sel=%0d",
                     req, cs, cfg_sel, want_cs, want_sel);
        end
    endtask

    always @(negedge clk) begin
        if (model_on) check(cur_req, exp_sel, exp_cs);
    end

    function automatic logic [NW:0] hot(int k);
        logic [NW:0] v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic set_win(int k, bit en, logic [AW-1:0] b, int sz);
        en_r[k-1]   = en;
        base_r[k-1] = b;
        size_r[k-1] = SW'(sz);
    endtask

    // One access: start, hold with wandering address, drop, check clear
    task automatic access(logic [AW-1:0] a, int hold, string req, int want);
        @(negedge clk); #1;
        cur_req = req;
        acc_valid = 1'b1;
        acc_addr = a;
        @(negedge clk);
        if (want >= 0) check(req, want, hot(want));
        for (int h = 0; h < hold; h++) begin
            #1 acc_addr = AW'($urandom);
            @(negedge clk);
        end
        #1 acc_valid = 1'b0;
        acc_addr = AW'($urandom);
        @(negedge clk);
        check("R10", 0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        set_win(1, 1, 24'h100000, 20);
        set_win(2, 1, 24'h180000, 16);
        set_win(3, 1, 24'h800000, 22);
        set_win(4, 1, 24'h900000, 12);
        repeat (3) @(negedge clk);
        check("R1", 0, '0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1", 0, '0);
        model_on = 1'b1;

        access(24'h100010, 2, "R2", 1);
        access(24'h1FFFFF, 0, "R2", 1);
        access(24'h180020, 1, "R5", 2);
        access(24'h200000, 0, "R6", 0);
        access(24'h0FFFFF, 0, "R6", 0);
        access(24'h900FFF, 3, "R5", 4);
        access(24'h901000, 0, "R2", 3);
        access(24'hBFFFFF, 0, "R2", 3);
        access(24'hC00000, 0, "R6", 0);

        // Misaligned base: low bits below size are ignored
        set_win(4, 1, 24'h900ABC, 12);
        access(24'h900000, 0, "R3", 4);
        // Disabled window loses the access to the one beneath it
        set_win(4, 0, 24'h900000, 12);
        access(24'h900010, 0, "R4", 3);
        // Upper pair over lower pair
        set_win(3, 1, 24'h100000, 20);
        access(24'h180020, 0, "R5", 3);
        set_win(4, 1, 24'h180000, 8);
        access(24'h180010, 0, "R5", 4);

        // Whole-space window and single-byte window
        set_win(1, 1, 24'h000000, 24);
        set_win(2, 1, 24'h123456, 0);
        set_win(3, 0, 24'h0, 0);
        set_win(4, 0, 24'h0, 0);
        access(24'hABCDEF, 0, "R2", 1);
        access(24'h123457, 0, "R2", 1);

        // Held access survives window changes
        @(negedge clk); #1;
        cur_req = "R9";
        acc_valid = 1'b1;
        acc_addr = 24'h123456;
        @(negedge clk);
        check("R8", 2, hot(2));
        #1 set_win(2, 0, 24'h123456, 0);
        acc_addr = 24'h000000;
        @(negedge clk);
        @(negedge clk);
        check("R9", 2, hot(2));
        #1 acc_valid = 1'b0;
        @(negedge clk);
        check("R10", 0, '0);

        // Randomised accesses, windows reshuffled periodically
        for (int n = 0; n < 300; n++) begin
            int pick;
            logic [AW-1:0] a;
            if (n % 20 == 0) begin
                for (int k = 1; k <= NW; k++)
                    set_win(k, bit'($urandom % 4 != 0), AW'($urandom), 8 + int'($urandom % 13));
            end
            pick = int'($urandom % NW);
            a = (n % 2 == 0) ? AW'($urandom) : (base_r[pick] ^ AW'($urandom % 512));
            access(a, int'($urandom % 4), "R5", -1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule